// File: doc/BRIEF.md
# Long-Vector Byte Serializer

This block takes a wide data word of configurable width from user logic and emits it one byte per clock toward a byte-wide 8b/10b transmit path. The user presents the word together with a one-cycle-or-longer valid strobe. If the block is idle on that clock edge, it captures the word. It then presents the bytes on consecutive cycles, starting with the most significant byte. A word whose width is not a whole number of bytes is extended with zero bits below its least significant bit.

While no word is in flight, the block sends the K28.5 comma byte (0xBC) and asserts the control-character enable. This lets the far end keep or regain word alignment. A word that is offered while a transfer is still running is discarded, not queued. The user watches the busy flag to know when a new word will be taken. Internally, a one-hot control register with one bit per byte steps a shift-by-8 data register. In the target system the byte clock runs at 250 MHz.

Top module: `vec_byte_serializer`

## Requirements
- R1: When `vecValid` is high and `busy` is low at a rising clock edge, the word on `vecIn` is captured, and its first byte appears on `byteOut` in the cycle that follows that edge.
- R2: A `vecValid` strobe seen while `busy` is high has no effect: that word is never sent, and the transfer in progress continues unchanged.
- R3: A captured word leaves as NBYTES = ceil(VEC_WIDTH/8) bytes on consecutive cycles, most significant byte first, one byte per cycle.
- R4: When VEC_WIDTH is not a multiple of 8, the word is extended with zero bits appended below bit 0, so the low bits of the final byte are 0. VEC_WIDTH must be at least 8.
- R5: `busy` is high in exactly the NBYTES cycles that present a data byte and drops in the cycle after the last one. A strobe in that cycle is accepted, so consecutive words are separated by at least one comma cycle.
- R6: In every cycle without a data byte, `byteOut` is 0xBC and `ctrlEn` is 1.
- R7: `byteValid` is 1 exactly in the cycles that present a data byte of a word, and `ctrlEn` is 0 in those cycles.
- R8: While `rstN` is low, the outputs show the idle state: comma byte, `ctrlEn` high, `byteValid` and `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| vecIn | input | VEC_WIDTH | User data word |
| vecValid | input | 1 | Word-valid strobe |
| byteOut | output | 8 | Byte to the encoder: data byte or comma |
| byteValid | output | 1 | High while `byteOut` carries a data byte |
| ctrlEn | output | 1 | High when `byteOut` is a control character |
| busy | output | 1 | High while a word is being sent |

## Verification
The bench uses a 20-bit word, so the final of three bytes carries four zero padding bits. A design that padded above the MSB, or left the bits unmasked, shows a wrong third byte. It holds the strobe high across whole transfers with changing data. A design that queued or captured a word mid-transfer would emit bytes the model never expected. A design that corrupted the running word would miscompare on the bytes in flight. Each cycle is compared against a cycle-stamped expected queue. An off-by-one in the control register length or in the busy release shows up as a missing comma gap, a short burst or a long burst. Single-bit words at both ends of the field catch byte-order and shift-direction mistakes.

// File: rtl/vbs_pkg.sv
package vbs_pkg;

  localparam logic [7:0] COMMA_K28_5 = 8'hBC;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // capture a new word this edge
    logic shift;   // advance the shift register by one byte
    logic active;  // a data byte is being presented this cycle
  } ctrlStrobes_t;

endpackage

// File: rtl/vbs_control.sv
module vbs_control
  import vbs_pkg::*;
#(
  parameter int NBYTES = 3
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         vecValid,
  output ctrlStrobes_t strobes,
  output logic         busy
);

  localparam int CNT_W = $clog2(NBYTES + 1) + 1;

  // One-hot sequence register: the set bit walks from the top down, one bit per byte
  logic [NBYTES-1:0] ctrlReg;
  logic              accept;

  assign busy   = |ctrlReg;
  assign accept = vecValid && !busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (accept) begin
      ctrlReg <= NBYTES'(1) << (NBYTES - 1);
    end else begin
      ctrlReg <= ctrlReg >> 1;
    end
  end

  always_comb begin
    strobes.load   = accept;
    strobes.shift  = busy;
    strobes.active = busy;
  end

  // Counter used only by the burst-length check below
  logic [CNT_W-1:0] burstCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     burstCnt <= '0;
    else if (busy) burstCnt <= burstCnt + 1'b1;
    else           burstCnt <= '0;
  end

  assert_onehot_seq_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctrlReg));

  assert_accept_R1: assert property (@(posedge clk) disable iff (!rstN)
    (vecValid && !busy) |=> busy);

  // R2 and R5: strobes during a transfer neither extend nor shorten it
  assert_burst_len_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (burstCnt == CNT_W'(NBYTES)));

endmodule

// File: rtl/vbs_datapath.sv
module vbs_datapath
  import vbs_pkg::*;
#(
  parameter int VEC_WIDTH = 20,
  parameter int NBYTES    = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [VEC_WIDTH-1:0] vecIn,
  input  ctrlStrobes_t         strobes,
  output logic [7:0]           byteOut,
  output logic                 ctrlEn
);

  localparam int PAD_W    = NBYTES * 8;
  localparam int PAD_BITS = PAD_W - VEC_WIDTH;

  logic [PAD_W-1:0] padded;
  logic [PAD_W-1:0] shiftReg;

  // Zero bits go below the LSB of the user word
  generate
    if (PAD_BITS == 0) begin : g_noPad
      assign padded = vecIn;
    end else begin : g_pad
      assign padded = {vecIn, {PAD_BITS{1'b0}}};
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobes.load) begin
      shiftReg <= padded;
    end else if (strobes.shift) begin
      shiftReg <= shiftReg << 8;
    end
  end

  always_comb begin
    if (strobes.active) begin
      byteOut = shiftReg[PAD_W-1 -: 8];
      ctrlEn  = 1'b0;
    end else begin
      byteOut = COMMA_K28_5;
      ctrlEn  = 1'b1;
    end
  end

  assert_first_byte_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (byteOut == $past(vecIn[VEC_WIDTH-1 -: 8])));

endmodule

// File: rtl/vec_byte_serializer.sv
module vec_byte_serializer
  import vbs_pkg::*;
#(
  parameter int VEC_WIDTH = 20
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [VEC_WIDTH-1:0] vecIn,
  input  logic                 vecValid,
  output logic [7:0]           byteOut,
  output logic                 byteValid,
  output logic                 ctrlEn,
  output logic                 busy
);

  localparam int NBYTES = (VEC_WIDTH + 7) / 8;

  ctrlStrobes_t strobes;
  logic         busyInt;

  vbs_control #(.NBYTES(NBYTES)) u_control (
    .clk      (clk),
    .rstN     (rstN),
    .vecValid (vecValid),
    .strobes  (strobes),
    .busy     (busyInt)
  );

  vbs_datapath #(.VEC_WIDTH(VEC_WIDTH), .NBYTES(NBYTES)) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .vecIn   (vecIn),
    .strobes (strobes),
    .byteOut (byteOut),
    .ctrlEn  (ctrlEn)
  );

  assign busy      = busyInt;
  assign byteValid = busyInt;

  initial begin
    assert_min_width_R4: assert (VEC_WIDTH >= 8);
  end

  assert_idle_comma_R6: assert property (@(posedge clk) disable iff (!rstN)
    !byteValid |-> (byteOut == COMMA_K28_5 && ctrlEn));

  assert_data_not_ctrl_R7: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> !ctrlEn);

endmodule

// File: tb/vec_byte_serializer_test.sv
module vec_byte_serializer_test;

  localparam int VW   = 20;
  localparam int NB   = (VW + 7) / 8;
  localparam int PW   = NB * 8;
  localparam int PADB = PW - VW;

  logic          clk = 1'b0;
  logic          rstN;
  logic [VW-1:0] vecIn;
  logic          vecValid;
  logic [7:0]    byteOut;
  logic          byteValid;
  logic          ctrlEn;
  logic          busy;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int left   = 0;   // model: data bytes still to show, counting the current cycle

  typedef struct {
    int         at;
    logic [7:0] b;
  } item_t;
  item_t expQ[$];

  always #10 clk = ~clk;   // 50 MHz

  vec_byte_serializer #(.VEC_WIDTH(VW)) uut (
    .clk       (clk),
    .rstN      (rstN),
    .vecIn     (vecIn),
    .vecValid  (vecValid),
    .byteOut   (byteOut),
    .byteValid (byteValid),
    .ctrlEn    (ctrlEn),
    .busy      (busy)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic report(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cycle %0d: actual %h expected %h", req, what, cyc, act, exp);
    end
  endtask

  // Monitor: compares each cycle against the cycle-stamped queue
  always @(negedge clk) begin
    if (!rstN) begin
      // R8 reset state
      report("R8", "reset outputs", {byteOut[7:0]}, 8'hBC);
      report("R8", "reset flags", {5'd0, byteValid, ctrlEn, busy}, 8'b0000_0010);
    end else if (expQ.size() != 0 && expQ[0].at == cyc) begin
      // R1 R3 R4: byte content and order; R7 R5: flags during data
      report("R1 R3 R4", "data byte", byteOut, expQ[0].b);
      report("R5 R7", "data flags", {5'd0, byteValid, ctrlEn, busy}, 8'b0000_0101);
      void'(expQ.pop_front());
    end else begin
      // R2 R5 R6: comma in every non-data cycle, dropped words never appear
      report("R2 R6", "idle byte", byteOut, 8'hBC);
      report("R5 R6", "idle flags", {5'd0, byteValid, ctrlEn, busy}, 8'b0000_0010);
    end
  end

  // Driver: called just after a rising edge, sets inputs for the next edge
  task automatic step(input logic valid, input logic [VW-1:0] v);
    logic [PW-1:0] p;
    @(posedge clk);
    #1;
    vecValid = valid;
    vecIn    = v;
    if (valid && left == 0) begin
      p = PW'(v) << PADB;   // R4 zero padding below bit 0
      for (int i = 0; i < NB; i++) begin
        item_t it;
        it.at = cyc + 1 + i;
        it.b  = p[PW-1-8*i -: 8];
        expQ.push_back(it);
      end
      left = NB;
    end else if (left > 0) begin
      left = left - 1;      // R2: strobe while busy is dropped
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, '0);
  endtask

  initial begin
    #(20 * 20000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rstN     = 1'b0;
    vecValid = 1'b0;
    vecIn    = '0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    idle(3);

    // single word, mixed pattern
    step(1'b1, 20'hA5C3E);
    idle(5);

    // byte order with single set bits at both ends (R3, R4)
    step(1'b1, 20'h80000);
    idle(4);
    step(1'b1, 20'h00001);
    idle(4);
    step(1'b1, 20'hFFFFF);
    idle(4);

    // strobe held high with changing data: drops and back-to-back acceptance (R2, R5)
    for (int i = 0; i < 14; i++) step(1'b1, 20'(32'h0F00D + i * 32'h1111F));
    idle(2);

    // strobe in the very cycle busy drops (R5)
    step(1'b1, 20'h12345);
    idle(2);
    step(1'b1, 20'h6789A);   // offered during the last byte: dropped
    step(1'b1, 20'hBCDEF);   // offered when busy is low: accepted
    idle(6);

    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R3 leftover bytes: actual %0d expected 0", expQ.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule